// File: doc/BRIEF.md
# Multi-channel DMA bus arbiter

This block decides which of several DMA requesters may use a shared bus master port. Three kinds of requester compete: a script-processor channel, an address-translation channel and a set of data channels. The top level is a three-slot round-robin. Its third slot is filled by whichever data channel sits at the head of a first-come-first-served queue.

A data channel joins the queue when its FIFO reports that it is ready for a transfer. The arbiter raises a bus request whenever any work is pending. It waits for the active-low grant, then hands one channel and its burst length to the master engine as a single start pulse. It waits for the engine to report that the burst is done, with or without a retry. The next burst then uses the next slot of the rotation.

Script-processor bursts are always 4 Dwords and address-translation bursts are always 2 Dwords. A data channel uses the length held in its own burst field.

Top module: `dma_bus_arbiter`

## Requirements
- R1: `bus_req` is high exactly when `scr_req` or `xlt_req` is high or at least one data channel holds a queue entry; a transfer never starts unless `bus_req` was high in the cycle before.
- R2: `xfer_start` rises only in the cycle after one in which `bus_gnt_n` was low. It is a one-cycle pulse, and no further start occurs until `xfer_done` has been seen for the current burst.
- R3: `xfer_chan` uses this encoding: 0 is the script processor, 1 is address translation, and 2+i is data channel i. `xfer_len` is 4 for code 0 and 2 for code 1. For data channel i it equals `data_burst[i*LEN_W +: LEN_W]`.
- R4: With all slots busy, service repeats the order address translation, script processor, queue head. The first burst after reset goes to address translation.
- R5: A slot with no request is passed over in the same arbitration decision, so the next requesting slot in rotation order is served without an idle burst.
- R6: Data channels are served in the order in which they entered the queue, not in index order.
- R7: When several data channels become ready in the same cycle, they enter the queue in ascending channel index.
- R8: A data channel holds at most one queue entry. A ready indication from a channel that is already queued adds nothing.
- R9: A data burst that ends with `xfer_retry` high keeps its queue entry. The same channel is served again the next time the data slot comes round. A burst that ends without retry removes the entry.
- R10: After reset the queue is empty, `bus_req` is low when no requester is active, and `xfer_start` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scr_req | input | 1 | Script-processor request (level) |
| xlt_req | input | 1 | Address-translation request (level) |
| data_ready | input | N_DATA | Per data channel: FIFO ready for a transfer |
| data_burst | input | N_DATA*LEN_W | Per data channel burst length in Dwords, channel i at bits i*LEN_W |
| bus_gnt_n | input | 1 | Active-low bus grant |
| xfer_done | input | 1 | Master engine finished the current burst |
| xfer_retry | input | 1 | Qualifies `xfer_done`: the burst was stopped by a retry |
| bus_req | output | 1 | Bus request toward the external bus |
| xfer_start | output | 1 | One-cycle pulse: start a burst |
| xfer_chan | output | CH_W | Channel code of the burst (see R3) |
| xfer_len | output | LEN_W | Burst length in Dwords |

## Verification
Two pairs of events can fall in the same cycle. The first is two data channels becoming ready together: the bench raises ready on channels 1 and 6 in one cycle and expects channel 1 to be served before channel 6. The second is a ready pulse from a channel that already holds an entry. The bench repeats channel 4's pulse while it is queued, serves it once, and then, with the grant held low, expects `bus_req` low and no further start. A retried burst that overlaps the script and translation slots is judged by the channel code that comes out at the next data slot.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        SLOT_XLT = 2'd0,
        SLOT_SCR = 2'd1,
        SLOT_DAT = 2'd2
    } slot_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic  valid;
        slot_e slot;
    } pick_t;

    localparam int SCR_BURST    = 4;
    localparam int XLT_BURST    = 2;
    localparam int CODE_SCR     = 0;
    localparam int CODE_XLT     = 1;
    localparam int CODE_DATA0   = 2;
    localparam int NUM_SLOTS    = 3;

    function automatic slot_e slot_plus(slot_e s, int k);
        logic [1:0] v;
        v = 2'((int'(s) + k) % NUM_SLOTS);
        return slot_e'(v);
    endfunction

endpackage

// File: rtl/dma_arb_queue.sv
module dma_arb_queue
    import dma_arb_pkg::*;
#(
    parameter int N_DATA = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_DATA-1:0]         ready,
    input  logic                      deq,
    output logic [$clog2(N_DATA)-1:0] head_ch,
    output logic                      nonempty
);
    localparam int IW = (N_DATA > 1) ? $clog2(N_DATA) : 1;
    localparam int CW = $clog2(N_DATA + 1);

    logic [IW-1:0]     slots [N_DATA];
    logic [IW-1:0]     head, tail;
    logic [CW-1:0]     count;
    logic [N_DATA-1:0] member;
    logic [N_DATA-1:0] fresh;
    logic [N_DATA-1:0] leave;
    logic [IW-1:0]     wpos [N_DATA];
    logic [CW-1:0]     nfresh;

    assign fresh    = ready & ~member;
    assign head_ch  = slots[head];
    assign nonempty = (count != '0);

    always_comb begin
        leave = '0;
        if (deq) leave[slots[head]] = 1'b1;
    end

    // arrivals of one cycle take consecutive tail positions, lowest index first
    always_comb begin
        nfresh = '0;
        for (int i = 0; i < N_DATA; i++) begin
            wpos[i] = IW'((int'(tail) + int'(nfresh)) % N_DATA);
            nfresh  = nfresh + CW'(fresh[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head   <= '0;
            tail   <= '0;
            count  <= '0;
            member <= '0;
            for (int i = 0; i < N_DATA; i++) slots[i] <= '0;
        end else begin
            for (int i = 0; i < N_DATA; i++) begin
                if (fresh[i]) slots[wpos[i]] <= IW'(i);
            end
            tail   <= IW'((int'(tail) + int'(nfresh)) % N_DATA);
            if (deq) head <= IW'((int'(head) + 1) % N_DATA);
            count  <= count + nfresh - CW'(deq);
            member <= (member & ~leave) | fresh;
        end
    end

    // R8
    member_count_chk: assert property (@(posedge clk) disable iff (rst)
        int'(count) == $countones(member));

    // R9
    deq_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        deq |-> (count != '0));

endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick
    import dma_arb_pkg::*;
(
    input  slot_e rr,
    input  logic  scr_req,
    input  logic  xlt_req,
    input  logic  dat_req,
    output pick_t pick
);
    slot_e cand;
    logic  cand_req;

    always_comb begin
        pick     = '{valid: 1'b0, slot: rr};
        cand     = rr;
        cand_req = 1'b0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            cand = slot_plus(rr, k);
            unique case (cand)
                SLOT_XLT: cand_req = xlt_req;
                SLOT_SCR: cand_req = scr_req;
                default:  cand_req = dat_req;
            endcase
            if (!pick.valid && cand_req) begin
                pick.valid = 1'b1;
                pick.slot  = cand;
            end
        end
    end

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
    import dma_arb_pkg::*;
#(
    parameter int N_DATA = 8,
    parameter int LEN_W  = 8,
    parameter int CH_W   = $clog2(N_DATA + 2)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scr_req,
    input  logic                    xlt_req,
    input  logic [N_DATA-1:0]       data_ready,
    input  logic [N_DATA*LEN_W-1:0] data_burst,
    input  logic                    bus_gnt_n,
    input  logic                    xfer_done,
    input  logic                    xfer_retry,
    output logic                    bus_req,
    output logic                    xfer_start,
    output logic [CH_W-1:0]         xfer_chan,
    output logic [LEN_W-1:0]        xfer_len
);
    localparam int IW = (N_DATA > 1) ? $clog2(N_DATA) : 1;

    arb_state_e st;
    slot_e      rr;
    slot_e      cur_slot;
    pick_t      pick;
    logic       q_nonempty;
    logic [IW-1:0] q_head;
    logic       deq;

    assign deq     = (st == ST_BUSY) && xfer_done && !xfer_retry && (cur_slot == SLOT_DAT);
    assign bus_req = scr_req | xlt_req | q_nonempty;

    dma_arb_queue #(.N_DATA(N_DATA)) queue_i (
        .clk      (clk),
        .rst      (rst),
        .ready    (data_ready),
        .deq      (deq),
        .head_ch  (q_head),
        .nonempty (q_nonempty)
    );

    dma_arb_rr_pick pick_i (
        .rr      (rr),
        .scr_req (scr_req),
        .xlt_req (xlt_req),
        .dat_req (q_nonempty),
        .pick    (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            rr         <= SLOT_XLT;
            cur_slot   <= SLOT_XLT;
            xfer_start <= 1'b0;
            xfer_chan  <= '0;
            xfer_len   <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (!bus_gnt_n && pick.valid) begin
                        xfer_start <= 1'b1;
                        cur_slot   <= pick.slot;
                        st         <= ST_BUSY;
                        unique case (pick.slot)
                            SLOT_SCR: begin
                                xfer_chan <= CH_W'(CODE_SCR);
                                xfer_len  <= LEN_W'(SCR_BURST);
                            end
                            SLOT_XLT: begin
                                xfer_chan <= CH_W'(CODE_XLT);
                                xfer_len  <= LEN_W'(XLT_BURST);
                            end
                            default: begin
                                xfer_chan <= CH_W'(CODE_DATA0 + int'(q_head));
                                xfer_len  <= data_burst[int'(q_head)*LEN_W +: LEN_W];
                            end
                        endcase
                    end
                end
                default: begin
                    xfer_start <= 1'b0;
                    if (xfer_done) begin
                        st <= ST_IDLE;
                        rr <= slot_plus(cur_slot, 1);
                    end
                end
            endcase
        end
    end

    // R2
    start_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> $past(!bus_gnt_n));

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start);

    // R1
    req_before_start_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> $past(bus_req));

    // R2
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY && !xfer_done) |=> !xfer_start);

endmodule

// File: tb/dma_bus_arbiter_tb_top.sv
module dma_bus_arbiter_tb_top;
    localparam int N_DATA = 8;
    localparam int LEN_W  = 8;
    localparam int CH_W   = 4;
    localparam int NSTEP  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scr_req = 1'b0, xlt_req = 1'b0;
    logic [N_DATA-1:0] data_ready = '0;
    logic [N_DATA*LEN_W-1:0] data_burst;
    logic bus_gnt_n = 1'b1, xfer_done = 1'b0, xfer_retry = 1'b0;
    logic bus_req, xfer_start;
    logic [CH_W-1:0] xfer_chan;
    logic [LEN_W-1:0] xfer_len;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_bus_arbiter #(.N_DATA(N_DATA), .LEN_W(LEN_W), .CH_W(CH_W)) dut_i (
        .clk(clk), .rst(rst), .scr_req(scr_req), .xlt_req(xlt_req),
        .data_ready(data_ready), .data_burst(data_burst), .bus_gnt_n(bus_gnt_n),
        .xfer_done(xfer_done), .xfer_retry(xfer_retry), .bus_req(bus_req),
        .xfer_start(xfer_start), .xfer_chan(xfer_chan), .xfer_len(xfer_len)
    );

    // {scr, xlt, ready pulse[7:0], retry, expected code[3:0], expected req}; code F = no service
    localparam logic [15:0] TBL [NSTEP] = '{
        {1'b1, 1'b1, 8'h00, 1'b0, 4'd1, 1'b1},  // R4 translation first
        {1'b1, 1'b1, 8'h00, 1'b0, 4'd0, 1'b1},  // R4 script next
        {1'b1, 1'b1, 8'h08, 1'b0, 4'd5, 1'b1},  // R4 queue head ch3
        {1'b0, 1'b0, 8'h20, 1'b0, 4'd7, 1'b1},  // R5 skip two idle slots
        {1'b1, 1'b0, 8'h20, 1'b0, 4'd0, 1'b1},  // R5 ch5 queued, script served
        {1'b1, 1'b0, 8'h04, 1'b0, 4'd7, 1'b1},  // R6 ch5 arrived first
        {1'b0, 1'b0, 8'h00, 1'b0, 4'd4, 1'b1},  // R6 then ch2
        {1'b0, 1'b0, 8'h42, 1'b0, 4'd3, 1'b1},  // R7 ch1 before ch6
        {1'b0, 1'b0, 8'h00, 1'b0, 4'd8, 1'b1},  // R7 ch6
        {1'b0, 1'b0, 8'h10, 1'b1, 4'd6, 1'b1},  // R9 ch4 retried
        {1'b1, 1'b1, 8'h00, 1'b0, 4'd1, 1'b1},  // R9 entry still pending
        {1'b1, 1'b1, 8'h00, 1'b0, 4'd0, 1'b1},  // R9
        {1'b1, 1'b1, 8'h00, 1'b0, 4'd6, 1'b1},  // R9 ch4 served again
        {1'b1, 1'b0, 8'h10, 1'b0, 4'd0, 1'b1},  // R8 ch4 queued
        {1'b1, 1'b0, 8'h10, 1'b0, 4'd6, 1'b1},  // R8 duplicate pulse ignored
        {1'b0, 1'b0, 8'h00, 1'b0, 4'hF, 1'b0}   // R8 nothing left
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int code);
        if (code == 0) return 4;
        if (code == 1) return 2;
        return 8 + (code - 2);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < N_DATA; i++) data_burst[i*LEN_W +: LEN_W] = LEN_W'(8 + i);
        repeat (3) @(negedge clk);
        // R10 state during and after reset
        check(bus_req == 1'b0, "R10 bus_req in reset", int'(bus_req), 0);
        check(xfer_start == 1'b0, "R10 start in reset", int'(xfer_start), 0);
        rst = 1'b0;
        bus_gnt_n = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_req == 1'b0, "R10 bus_req after reset", int'(bus_req), 0);
        check(xfer_start == 1'b0, "R10 no start with empty queue", int'(xfer_start), 0);
        bus_gnt_n = 1'b1;
        @(negedge clk);

        for (int s = 0; s < NSTEP; s++) begin
            logic [15:0] v;
            int code;
            bit seen;
            v = TBL[s];
            code = int'(v[4:1]);
            scr_req = v[15];
            xlt_req = v[14];
            data_ready = v[13:6];
            @(negedge clk);
            data_ready = '0;
            for (int w = 0; w < 3; w++) begin
                check(xfer_start == 1'b0, "R2 no start without grant", int'(xfer_start), 0);
                @(negedge clk);
            end
            check(bus_req == v[0], "R1 bus_req level", int'(bus_req), int'(v[0]));
            bus_gnt_n = 1'b0;
            if (code == 15) begin
                for (int w = 0; w < 6; w++) begin
                    @(negedge clk);
                    check(xfer_start == 1'b0, "R8 no extra service", int'(xfer_start), 0);
                end
            end else begin
                seen = 1'b0;
                for (int w = 0; w < 20 && !seen; w++) begin
                    @(negedge clk);
                    if (xfer_start) seen = 1'b1;
                end
                check(seen, "R2 start after grant", int'(seen), 1);
                check(int'(xfer_chan) == code, "R3/R4 channel code", int'(xfer_chan), code);
                check(int'(xfer_len) == exp_len(code), "R3 burst length", int'(xfer_len), exp_len(code));
                xfer_done = 1'b1;
                xfer_retry = v[5];
                @(negedge clk);
                xfer_done = 1'b0;
                xfer_retry = 1'b0;
                bus_gnt_n = 1'b1;
                check(xfer_start == 1'b0, "R2 single pulse", int'(xfer_start), 0);
            end
            bus_gnt_n = 1'b1;
            @(negedge clk);
        end
        finish_run();
    end

endmodule